// File: doc/BRIEF.md
# Mode-Aware Register Id Mapper

This block turns an architectural register reference into a single 7-bit register id that the forwarding and dependency logic of an out-of-order core uses to compare operands. A reference names a register class (general, predicate, code address, segment, special) and an index within that class. Every class is packed into one shared id space, so two references collide only when they name the same physical register.

The stack-pointer register of the general file is aliased by the core's operating mode. A reference to general register 27 is redirected to 27 plus the mode number, so the same code runs in every mode with its own stack. Registers 28 to 31 hold the stack pointers of the privileged modes. A direct reference to them from user mode is refused with a privilege fault.

The current mode is held inside the block. A mode-change request loads a new mode and raises a one-cycle flush request, because ids of in-flight work may not mix mappings from two modes. Each result is registered, so it appears one clock after its request.

Top module: `regid_mapper`

## Requirements
- R1: A general-class reference (class code 0) with index 0 to 63 yields id equal to the index with valid set, except for the cases in R6 and R7.
- R2: A predicate reference (class code 1) with index 0 to 15 yields id 64 plus the index.
- R3: A code-address reference (class code 2) with index 0 to 15 yields id 80 plus the index.
- R4: A segment reference (class code 3) with index 0 to 15 yields id 96 plus the index: indices 0 to 7 are the base registers (ids 96 to 103) and 8 to 15 the limit registers (ids 104 to 111).
- R5: A special-register reference (class code 4) with index 0 to 15 yields id 112 plus the index.
- R6: General index 27 yields id 27 plus the mode number, where the mode encoding is 0 user, 1 interrupt, 2 exception, 3 debug: ids 27, 28, 29, 30.
- R7: General index 28 to 31 in user mode sets the fault output, clears valid and gives id 0; in modes 1 to 3 the same index maps directly with valid set and no fault.
- R8: An index of 16 or more in classes 1 to 4, or any class code 5 to 7, clears valid, gives id 0 and no fault.
- R9: The id, valid and fault outputs reflect the request presented one clock earlier; a cycle with no request gives id 0, valid and fault clear.
- R10: A mode change raises the flush output for exactly the one cycle after the request, the mode output shows the new mode from that same cycle, and a reference presented together with the mode change still uses the old mode.
- R11: While reset is asserted the mode is user and the id, valid, fault and flush outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_chg_i | input | 1 | Request to load a new operating mode |
| mode_new_i | input | 2 | Mode loaded when mode_chg_i is high |
| req_i | input | 1 | A register reference is presented this cycle |
| class_i | input | 3 | Register class code |
| index_i | input | 6 | Register index within the class |
| id_o | output | 7 | Unified register id |
| valid_o | output | 1 | The id names an existing, permitted register |
| fault_o | output | 1 | Privilege fault on the reference |
| flush_o | output | 1 | Pipeline flush request after a mode change |
| mode_o | output | 2 | Mode currently used for mapping |

## Verification
On every cycle the assertions check that a fault never coexists with a valid id, that an invalid result carries id 0, that a valid result always follows a request, that a fault only arises from a user-mode reference and that the held mode never changes without a flush. Only the bench's scenarios can show the actual id values for each class and its boundary indices, the stack-pointer alias in all four modes, and that a reference issued in the same cycle as a mode change still maps with the old mode while the next one uses the new.

// File: rtl/regid_pkg.sv
package regid_pkg;

    localparam int ID_W      = 7;
    localparam int IDX_W     = 6;
    localparam int CLS_W     = 3;
    localparam int MODE_W    = 2;
    localparam int GPR_CNT   = 64;
    localparam int SMALL_CNT = 16;
    localparam int SMALL_CLS = 4;
    localparam int SP_INDEX  = 27;
    localparam int PRIV_LO   = 28;
    localparam int PRIV_HI   = 31;

    typedef enum logic [CLS_W-1:0] {
        CLS_GPR   = 3'd0,
        CLS_PRED  = 3'd1,
        CLS_CADDR = 3'd2,
        CLS_SEG   = 3'd3,
        CLS_SPEC  = 3'd4
    } reg_class_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_USER = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_EXC  = 2'd2,
        MODE_DBG  = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            valid;
        logic            fault;
    } map_res_t;

endpackage

// File: rtl/regid_mode_ctl.sv
module regid_mode_ctl
    import regid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_chg_i,
    input  logic [MODE_W-1:0] mode_new_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              flush_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              flush;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flush = mode_chg_i;
        if (mode_chg_i) begin
            st_d.mode = mode_new_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign flush_o = st_q.flush;

    AST_MODE_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> st_q.flush) else $error("mode moved without flush"); // R10

endmodule

// File: rtl/regid_decode.sv
module regid_decode
    import regid_pkg::*;
(
    input  logic              req_i,
    input  logic [CLS_W-1:0]  class_i,
    input  logic [IDX_W-1:0]  index_i,
    input  logic [MODE_W-1:0] mode_i,
    output map_res_t          res_o
);

    logic [SMALL_CLS-1:0] small_hit;
    logic [ID_W-1:0]      small_id [SMALL_CLS];

    // Predicate, code-address, segment and special classes: 16-entry windows
    // laid one after another above the general file.
    for (genvar k = 0; k < SMALL_CLS; k++) begin : g_small
        assign small_hit[k] = (class_i == CLS_W'(k + 1)) && (index_i < IDX_W'(SMALL_CNT));
        assign small_id[k]  = ID_W'(GPR_CNT + k * SMALL_CNT) + ID_W'(index_i);
    end

    logic gpr_sel, is_sp, is_priv, user_mode;

    assign gpr_sel   = (class_i == CLS_GPR);
    assign is_sp     = (index_i == IDX_W'(SP_INDEX));
    assign is_priv   = (index_i >= IDX_W'(PRIV_LO)) && (index_i <= IDX_W'(PRIV_HI));
    assign user_mode = (mode_i == MODE_USER);

    always_comb begin
        res_o = '0;
        if (req_i) begin
            if (gpr_sel) begin
                if (is_sp) begin
                    res_o.id    = ID_W'(SP_INDEX) + ID_W'(mode_i);
                    res_o.valid = 1'b1;
                end else if (is_priv && user_mode) begin
                    res_o.fault = 1'b1;
                end else begin
                    res_o.id    = ID_W'(index_i);
                    res_o.valid = 1'b1;
                end
            end else begin
                for (int j = 0; j < SMALL_CLS; j++) begin
                    if (small_hit[j]) begin
                        res_o.id    = small_id[j];
                        res_o.valid = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/regid_mapper.sv
module regid_mapper
    import regid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_chg_i,
    input  logic [MODE_W-1:0] mode_new_i,
    input  logic              req_i,
    input  logic [CLS_W-1:0]  class_i,
    input  logic [IDX_W-1:0]  index_i,
    output logic [ID_W-1:0]   id_o,
    output logic              valid_o,
    output logic              fault_o,
    output logic              flush_o,
    output logic [MODE_W-1:0] mode_o
);

    logic [MODE_W-1:0] cur_mode;
    map_res_t          res_d, res_q;

    regid_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_chg_i (mode_chg_i),
        .mode_new_i (mode_new_i),
        .mode_o     (cur_mode),
        .flush_o    (flush_o)
    );

    regid_decode u_dec (
        .req_i   (req_i),
        .class_i (class_i),
        .index_i (index_i),
        .mode_i  (cur_mode),
        .res_o   (res_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign id_o    = res_q.id;
    assign valid_o = res_q.valid;
    assign fault_o = res_q.fault;
    assign mode_o  = cur_mode;

    AST_FAULT_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !valid_o) else $error("fault with valid id"); // R7

    AST_INVALID_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (id_o == '0)) else $error("invalid result with nonzero id"); // R8

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(req_i)) else $error("valid without request"); // R9

    AST_FAULT_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> ($past(cur_mode) == MODE_USER)) else $error("fault outside user mode"); // R7

endmodule

// File: tb/regid_mapper_bench.sv
module regid_mapper_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_chg_i;
    logic [1:0] mode_new_i;
    logic       req_i;
    logic [2:0] class_i;
    logic [5:0] index_i;
    logic [6:0] id_o;
    logic       valid_o, fault_o, flush_o;
    logic [1:0] mode_o;

    always #2.5 clk = ~clk;

    regid_mapper u_regid_mapper (
        .clk(clk), .rst_n(rst_n), .mode_chg_i(mode_chg_i), .mode_new_i(mode_new_i),
        .req_i(req_i), .class_i(class_i), .index_i(index_i), .id_o(id_o),
        .valid_o(valid_o), .fault_o(fault_o), .flush_o(flush_o), .mode_o(mode_o)
    );

    typedef struct {
        logic [6:0] id;
        logic       v;
        logic       f;
        logic       fl;
        logic [1:0] md;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [1:0] m = 2'd0;
    bit         done = 0;

    function automatic exp_t model(bit req, logic [2:0] cls, logic [5:0] idx, logic [1:0] md);
        exp_t e;
        e.id = 7'd0; e.v = 1'b0; e.f = 1'b0; e.fl = 1'b0; e.md = md;
        if (!req) begin
            e.tag = "R9";
        end else if (cls > 3'd4 || (cls != 3'd0 && idx > 6'd15)) begin
            e.tag = "R8";
        end else if (cls == 3'd0) begin
            if (idx == 6'd27) begin
                e.tag = "R6"; e.v = 1'b1; e.id = 7'd27 + {5'd0, md};
            end else if (idx >= 6'd28 && idx <= 6'd31) begin
                e.tag = "R7";
                if (md == 2'd0) e.f = 1'b1;
                else begin e.v = 1'b1; e.id = {1'b0, idx}; end
            end else begin
                e.tag = "R1"; e.v = 1'b1; e.id = {1'b0, idx};
            end
        end else begin
            e.v = 1'b1;
            case (cls)
                3'd1: begin e.tag = "R2"; e.id = 7'd64  + {1'b0, idx}; end
                3'd2: begin e.tag = "R3"; e.id = 7'd80  + {1'b0, idx}; end
                3'd3: begin e.tag = "R4"; e.id = 7'd96  + {1'b0, idx}; end
                default: begin e.tag = "R5"; e.id = 7'd112 + {1'b0, idx}; end
            endcase
        end
        return e;
    endfunction

    task automatic drive(bit req, logic [2:0] cls, logic [5:0] idx, bit mc, logic [1:0] nm);
        exp_t e;
        @(negedge clk);
        req_i = req; class_i = cls; index_i = idx; mode_chg_i = mc; mode_new_i = nm;
        e = model(req, cls, idx, m);
        e.fl = mc;
        if (mc) begin
            m = nm;
            e.md = nm;
        end
        sb.push_back(e);
    endtask

    task automatic ref_reg(logic [2:0] cls, logic [5:0] idx);
        drive(1'b1, cls, idx, 1'b0, 2'd0);
    endtask

    task automatic set_mode(logic [1:0] nm);
        drive(1'b0, 3'd0, 6'd0, 1'b1, nm);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (id_o !== e.id || valid_o !== e.v || fault_o !== e.f) begin
                    errors++;
                    $display("FAIL %s: id/valid/fault = %0d/%0b/%0b expected %0d/%0b/%0b",
                             e.tag, id_o, valid_o, fault_o, e.id, e.v, e.f);
                end
                checks++;
                if (flush_o !== e.fl || mode_o !== e.md) begin
                    errors++;
                    $display("FAIL R10: flush/mode = %0b/%0d expected %0b/%0d",
                             flush_o, mode_o, e.fl, e.md);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_i = 1'b0; class_i = '0; index_i = '0;
        mode_chg_i = 1'b1; mode_new_i = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (id_o !== 7'd0 || valid_o !== 1'b0 || fault_o !== 1'b0 || flush_o !== 1'b0 || mode_o !== 2'd0) begin
            errors++;
            $display("FAIL R11: id/v/f/fl/mode = %0d/%0b/%0b/%0b/%0d expected 0/0/0/0/0",
                     id_o, valid_o, fault_o, flush_o, mode_o);
        end
        mode_chg_i = 1'b0;
        rst_n = 1'b1;

        // R1 general file, user mode
        ref_reg(3'd0, 6'd0);
        ref_reg(3'd0, 6'd26);
        ref_reg(3'd0, 6'd32);
        ref_reg(3'd0, 6'd63);
        // R2..R5 small classes with edges
        ref_reg(3'd1, 6'd0);
        ref_reg(3'd1, 6'd15);
        ref_reg(3'd2, 6'd5);
        ref_reg(3'd3, 6'd7);
        ref_reg(3'd3, 6'd8);
        ref_reg(3'd3, 6'd15);
        ref_reg(3'd4, 6'd15);
        ref_reg(3'd4, 6'd0);
        // R8 out of range
        ref_reg(3'd1, 6'd16);
        ref_reg(3'd2, 6'd63);
        ref_reg(3'd5, 6'd1);
        ref_reg(3'd6, 6'd0);
        ref_reg(3'd7, 6'd27);
        // R6 / R7 user mode
        ref_reg(3'd0, 6'd27);
        for (int i = 28; i <= 31; i++) ref_reg(3'd0, 6'(i));
        // R9 idle gap
        drive(1'b0, 3'd0, 6'd5, 1'b0, 2'd0);
        // R10 reference in the same cycle as the change uses the old mode
        drive(1'b1, 3'd0, 6'd27, 1'b1, 2'd3);
        ref_reg(3'd0, 6'd27);
        ref_reg(3'd0, 6'd30);
        ref_reg(3'd0, 6'd31);
        // each privileged mode, back-to-back changes
        set_mode(2'd1);
        set_mode(2'd2);
        ref_reg(3'd0, 6'd27);
        ref_reg(3'd0, 6'd28);
        set_mode(2'd1);
        ref_reg(3'd0, 6'd27);
        ref_reg(3'd0, 6'd29);
        drive(1'b1, 3'd0, 6'd28, 1'b1, 2'd0);
        ref_reg(3'd0, 6'd28);
        ref_reg(3'd0, 6'd27);
        set_mode(2'd0);
        ref_reg(3'd1, 6'd9);
        drive(1'b0, 3'd0, 6'd0, 1'b0, 2'd0);

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule